// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port with a small register bus. Software sets an output value and a per-pin output enable, and it reads back the pin levels after they are synchronised. Every pin can raise an interrupt. The trigger can be a low level, a high level, a rising edge or a falling edge. A separate per-pin override makes the pin fire on both edges.

Detected events are held in a sticky status register. Software clears a status bit by writing a one to it. A mask register chooses which pending bits reach the two interrupt lines: one line serves pins 0 to 15 and the other serves pins 16 to 31. Pad inputs pass through a two-flop synchroniser before they are used. The asynchronous active-low reset is released synchronously inside the block.

Writes take effect on the clock edge at which `bus_we` is sampled high. Reads are combinational from `bus_addr`. Addresses are byte offsets of 32-bit words.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the output value, output-enable, both trigger-config words, mask and both-edge registers read as zero, and both interrupt lines are low.
- R2: The word at offset 0x00 drives `pad_out`. The word at offset 0x04 drives `pad_oe` (1 = output). Both read back the value that was written.
- R3: Offset 0x08 returns the pad levels after a two-flop synchroniser. A change made before a clock edge is therefore visible after the second edge and not after the first. A write to 0x08 has no effect.
- R4: The 2-bit trigger field of pin n sits at bits [2*(n mod 16)+1 : 2*(n mod 16)]. Pins 0–15 use the word at 0x0C and pins 16–31 use the word at 0x10. Code 00 selects low level: the status bit is set while the synchronised pin is 0.
- R5: Code 01 selects high level: the status bit is set while the synchronised pin is 1.
- R6: Code 10 selects rising edge. The status bit is set once when the synchronised pin goes 0→1, and not on 1→0.
- R7: Code 11 selects falling edge. The status bit is set once when the synchronised pin goes 1→0, and not on 0→1.
- R8: A 1 in the pin's bit of the word at 0x1C makes that pin detect both edges, whatever its 2-bit field holds.
- R9: The status word at 0x18 is sticky. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and writing all ones clears every pending bit.
- R10: When a detection and a clear hit the same status bit in the same cycle, the detection wins. A level-triggered bit therefore stays set while its level holds.
- R11: `irq_lo` is high when a pending bit among pins 0–15 has its mask bit (word 0x14) at 1. `irq_hi` does the same for pins 16–31. A pending pin with mask 0 drives neither line.
- R12: A read from any offset other than 0x00–0x1C returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a fresh detection on the same bit. The bench produces it with a level trigger. It holds a pin at its active level and writes the clear while the condition persists, which forces the collision on the exact edge of the write. It then removes the level and checks that the next clear takes effect. Edge modes are run on one pin in both directions, so that the direction that must be ignored is seen as well. The both-edge override is enabled on a pin whose field holds a single-edge code, so the override is proven rather than matched by the field.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned PORT_W = 32;
  localparam int unsigned OFFS_W = 6;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam logic [7:0] OFF_DOUT = 8'h00;
  localparam logic [7:0] OFF_DIR  = 8'h04;
  localparam logic [7:0] OFF_PAD  = 8'h08;
  localparam logic [7:0] OFF_CFGL = 8'h0C;
  localparam logic [7:0] OFF_CFGH = 8'h10;
  localparam logic [7:0] OFF_MASK = 8'h14;
  localparam logic [7:0] OFF_STAT = 8'h18;
  localparam logic [7:0] OFF_BOTH = 8'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W      = PORT_W,
  parameter int unsigned ADDR_W = OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      pad_lvl,
  input  logic [W-1:0]      status_q,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      cfg_lo_q,
  output logic [W-1:0]      cfg_hi_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      both_q,
  output logic [W-1:0]      stat_clr
);
  logic wr_dout, wr_dir, wr_cfgl, wr_cfgh, wr_mask, wr_both, wr_stat, wr_pad;
  logic [W-1:0] dout_d, dir_d, cfgl_d, cfgh_d, mask_d, both_d;

  assign wr_dout = bus_we && (bus_addr == OFF_DOUT[ADDR_W-1:0]);
  assign wr_dir  = bus_we && (bus_addr == OFF_DIR[ADDR_W-1:0]);
  assign wr_pad  = bus_we && (bus_addr == OFF_PAD[ADDR_W-1:0]);
  assign wr_cfgl = bus_we && (bus_addr == OFF_CFGL[ADDR_W-1:0]);
  assign wr_cfgh = bus_we && (bus_addr == OFF_CFGH[ADDR_W-1:0]);
  assign wr_mask = bus_we && (bus_addr == OFF_MASK[ADDR_W-1:0]);
  assign wr_stat = bus_we && (bus_addr == OFF_STAT[ADDR_W-1:0]);
  assign wr_both = bus_we && (bus_addr == OFF_BOTH[ADDR_W-1:0]);

  assign stat_clr = wr_stat ? bus_wdata : '0;

  always_comb begin
    dout_d = wr_dout ? bus_wdata : dout_q;
    dir_d  = wr_dir  ? bus_wdata : dir_q;
    cfgl_d = wr_cfgl ? bus_wdata : cfg_lo_q;
    cfgh_d = wr_cfgh ? bus_wdata : cfg_hi_q;
    mask_d = wr_mask ? bus_wdata : mask_q;
    both_d = wr_both ? bus_wdata : both_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
    end else begin
      dout_q   <= dout_d;
      dir_q    <= dir_d;
      cfg_lo_q <= cfgl_d;
      cfg_hi_q <= cfgh_d;
      mask_q   <= mask_d;
      both_q   <= both_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_DOUT[ADDR_W-1:0]: bus_rdata = dout_q;
      OFF_DIR[ADDR_W-1:0]:  bus_rdata = dir_q;
      OFF_PAD[ADDR_W-1:0]:  bus_rdata = pad_lvl;
      OFF_CFGL[ADDR_W-1:0]: bus_rdata = cfg_lo_q;
      OFF_CFGH[ADDR_W-1:0]: bus_rdata = cfg_hi_q;
      OFF_MASK[ADDR_W-1:0]: bus_rdata = mask_q;
      OFF_STAT[ADDR_W-1:0]: bus_rdata = status_q;
      OFF_BOTH[ADDR_W-1:0]: bus_rdata = both_q;
      default:              bus_rdata = '0;
    endcase
  end

  // R3: a write to the read-only level word leaves the writable words alone
  a_r3_pad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pad |=> ($stable(dout_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] cfg_lo,
  input  logic [W-1:0] cfg_hi,
  input  logic [W-1:0] both_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status_q
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] prev_q;
  logic [W-1:0] set_vec;
  logic [W-1:0] status_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam int unsigned B = 2 * (i % HALF);
    trig_e mode;
    logic  rise, fall;
    if (i < HALF) begin : g_lo
      assign mode = trig_e'(cfg_lo[B+1:B]);
    end else begin : g_hi
      assign mode = trig_e'(cfg_hi[B+1:B]);
    end
    assign rise = lvl[i] & ~prev_q[i];
    assign fall = ~lvl[i] & prev_q[i];
    always_comb begin
      if (both_en[i]) begin
        set_vec[i] = rise | fall;
      end else begin
        case (mode)
          TRIG_LOW:  set_vec[i] = ~lvl[i];
          TRIG_HIGH: set_vec[i] = lvl[i];
          TRIG_RISE: set_vec[i] = rise;
          default:   set_vec[i] = fall;
        endcase
      end
    end
  end

  assign status_d = (status_q & ~clr) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl;
      status_q <= status_d;
    end
  end

  // R10: a detection always lands, even against a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R9: a cleared bit with no concurrent detection is zero afterwards
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set_vec)) |=> ((status_q & $past(clr & ~set_vec)) == '0));

  // R9: bits neither detected nor cleared keep their value
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(set_vec | clr)) == ($past(status_q) & ~$past(set_vec | clr))));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W      = PORT_W,
  parameter int unsigned ADDR_W = OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int unsigned HALF = W / 2;

  logic [1:0]   rst_pipe_q;
  logic         rst_int_n;
  logic [W-1:0] pad_lvl;
  logic [W-1:0] status_q, stat_clr;
  logic [W-1:0] cfg_lo_q, cfg_hi_q, mask_q, both_q;
  logic [W-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpio_sync #(.W(W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async (pad_in),
    .d_sync  (pad_lvl)
  );

  gpio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_lvl   (pad_lvl),
    .status_q  (status_q),
    .bus_rdata (bus_rdata),
    .dout_q    (pad_out),
    .dir_q     (pad_oe),
    .cfg_lo_q  (cfg_lo_q),
    .cfg_hi_q  (cfg_hi_q),
    .mask_q    (mask_q),
    .both_q    (both_q),
    .stat_clr  (stat_clr)
  );

  gpio_irq_detect #(.W(W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lvl      (pad_lvl),
    .cfg_lo   (cfg_lo_q),
    .cfg_hi   (cfg_hi_q),
    .both_en  (both_q),
    .clr      (stat_clr),
    .status_q (status_q)
  );

  assign pend   = status_q & mask_q;
  assign irq_lo = |pend[HALF-1:0];
  assign irq_hi = |pend[W-1:HALF];

  // R11: with the low half fully masked off, the low line stays quiet
  a_r11_lo_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_q[HALF-1:0] == '0) |-> !irq_lo);

  // R11: with no high-half bit pending, the high line stays quiet
  a_r11_hi_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_q[W-1:HALF] == '0) |-> !irq_hi);
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] CFG_HIGH_ALL = 32'h5555_5555;

  always #2 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h00, v); chk("R1 dout", v, 0);
    rd(6'h04, v); chk("R1 dir", v, 0);
    rd(6'h0C, v); chk("R1 cfg lo", v, 0);
    rd(6'h10, v); chk("R1 cfg hi", v, 0);
    rd(6'h14, v); chk("R1 mask", v, 0);
    rd(6'h1C, v); chk("R1 both", v, 0);
    chk("R1 irq lines", {30'd0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_base;
    logic [31:0] v;
    wr(6'h0C, CFG_HIGH_ALL);
    wr(6'h10, CFG_HIGH_ALL);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R9 clear all", v, 0);
  endtask

  task automatic t_data_dir;
    logic [31:0] v;
    wr(6'h00, 32'hA5A5_0F0F);
    wr(6'h04, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(6'h00, v); chk("R2 dout readback", v, 32'hA5A5_0F0F);
    rd(6'h04, v); chk("R2 dir readback", v, 32'hFFFF_0000);
  endtask

  task automatic t_high_level;
    logic [31:0] v;
    set_pads(32'h0000_0008);
    rd(6'h18, v); chk("R5 high level pin3", v, 32'h0000_0008);
    wr(6'h18, 32'h0000_0008);
    rd(6'h18, v); chk("R10 level set beats clear", v, 32'h0000_0008);
    set_pads(32'h0);
    wr(6'h18, 32'h0000_0008);
    rd(6'h18, v); chk("R10 clear after level drops", v, 0);
  endtask

  task automatic t_low_level;
    logic [31:0] v;
    wr(6'h10, 32'h5555_5455);
    repeat (2) @(negedge clk);
    rd(6'h18, v); chk("R4 low level pin20", v, 32'h0010_0000);
    wr(6'h10, CFG_HIGH_ALL);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R4 cleared after restore", v, 0);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    wr(6'h0C, 32'h5555_5955);
    set_pads(32'h0000_0020);
    rd(6'h18, v); chk("R6 rise pin5", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); chk("R6 edge clears while high", v, 0);
    set_pads(32'h0);
    rd(6'h18, v); chk("R6 no set on fall", v, 0);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    wr(6'h0C, 32'h5555_5D55);
    set_pads(32'h0000_0020);
    rd(6'h18, v); chk("R7 no set on rise", v, 0);
    set_pads(32'h0);
    rd(6'h18, v); chk("R7 fall pin5", v, 32'h0000_0020);
    wr(6'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_both;
    logic [31:0] v;
    wr(6'h0C, 32'h5555_5955);
    wr(6'h1C, 32'h0000_0020);
    set_pads(32'h0000_0020);
    rd(6'h18, v); chk("R8 both rise", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    set_pads(32'h0);
    rd(6'h18, v); chk("R8 both fall overrides field", v, 32'h0000_0020);
    wr(6'h18, 32'h0);
    rd(6'h18, v); chk("R9 write zero keeps bit", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); chk("R9 write one clears", v, 0);
    wr(6'h1C, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(6'h10, 32'h5555_5655);
    set_pads(32'h0010_0020);
    rd(6'h18, v); chk("R11 both pending", v, 32'h0010_0020);
    chk("R11 masked lines", {30'd0, irq_hi, irq_lo}, 0);
    wr(6'h14, 32'h0000_0020);
    chk("R11 low line only", {30'd0, irq_hi, irq_lo}, 32'd1);
    wr(6'h14, 32'h0010_0020);
    chk("R11 both lines", {30'd0, irq_hi, irq_lo}, 32'd3);
    wr(6'h18, 32'hFFFF_FFFF);
    chk("R11 lines drop on clear", {30'd0, irq_hi, irq_lo}, 0);
    wr(6'h14, 32'h0);
    set_pads(32'h0);
    wr(6'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_pad_status;
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    #1 bus_addr = 6'h08;
    #0 v = bus_rdata;
    chk("R3 not yet after one edge", v, 32'h0);
    @(negedge clk);
    #1 v = bus_rdata;
    chk("R3 visible after two edges", v, 32'h1234_5678);
    wr(6'h08, 32'h0);
    rd(6'h08, v); chk("R3 write ignored", v, 32'h1234_5678);
    rd(6'h00, v); chk("R3 write left dout", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(6'h24, v); chk("R12 unmapped 0x24", v, 0);
    rd(6'h3C, v); chk("R12 unmapped 0x3C", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_base();
        t_data_dir();
        t_high_level();
        t_low_level();
        t_rise();
        t_fall();
        t_both();
        t_mask();
        t_pad_status();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule